// File: doc/BRIEF.md
# Real-Style Segmented Address Generator

This block forms the linear address for a memory access made by 16-bit legacy code that runs under a virtual-machine mode. It shifts the 16-bit segment value left by four bit positions and adds the offset, zero-extended, to that base. The carry out of bit 19 is kept, so results reach just past one megabyte. The offset is checked in the same pass. Access through the stack segment faults with vector 12. Access through a data segment, and sequential instruction fetch, fault with vector 13. In every case the address does not wrap silently.

A test-only control can drop bit 20 of the result, which gives the wrap at one megabyte that older parts had. The datapath is combinational. A parameter adds one register stage at the outputs, and that stage is on by default.

Top module: `seg_addr_gen`

## Requirements
- R1: With no fault, the linear address equals segment × 16 plus the low 16 bits of the effective address, computed to 21 bits with the carry kept.
- R2: Bits 31 down to 21 of the linear address are always zero. Segment 0xFFFF with offset 0xFFFF gives 0x10FFEF.
- R3: An effective address above 0xFFFF raises a fault. This includes 0xFFFFFFFF, where the end-offset sum must not overflow.
- R4: The operand byte count is 2 when op_size is 2, 4 when op_size is 4, and 1 for every other op_size value. A fault is raised when the offset plus the byte count minus 1 exceeds 0xFFFF. A dword at 0xFFFC does not fault. A dword at 0xFFFD does fault.
- R5: When stack_acc=1 and fetch_seq=0, a fault carries vector 12 on fault_vec. Any other fault carries vector 13.
- R6: While fault_vld is 1, lin_addr is zero. While fault_vld is 0, fault_vec is zero.
- R7: When fetch_seq=1 and the fetch runs past offset 0xFFFF, the fault vector is 13 even if stack_acc=1. Offset 0 is never used in place of the overrun.
- R8: When wrap_en=1, bit 20 of the result is cleared, so 0xFFFF:0xFFFF gives 0x0FFEF.
- R9: When REG_OUT=1 (the default), each output reflects the inputs sampled at the previous rising clock edge. While rst_n is low at an edge, all outputs are set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_val | input | 16 | Segment value |
| eff_addr | input | 32 | Effective address (offset) |
| op_size | input | 3 | Operand bytes: 2, 4, anything else means 1 |
| stack_acc | input | 1 | Access goes through the stack segment |
| fetch_seq | input | 1 | Access is a sequential instruction fetch |
| wrap_en | input | 1 | Clear bit 20 of the result |
| lin_addr | output | 32 | Linear address, zero when a fault is raised |
| fault_vld | output | 1 | A fault is raised for this access |
| fault_vec | output | 8 | Fault vector: 12, 13, or 0 when there is no fault |

## Verification
The hardest cases to reach from the ports are the edges of the crossing check. These are a dword at 0xFFFC against one at 0xFFFD, and an effective address of 0xFFFFFFFF, where a 32-bit end-offset sum would wrap back to a small value. The bench drives each of these offsets directly. It also drives the combination of stack access and fetch, which must still give vector 13. Random vectors are biased toward offsets near 0xFFFF so that crossings occur often. A behavioural model checks every clock, one cycle late, so the register stage is verified along with the datapath.

// File: rtl/seg_addr_pkg.sv
// Package: shared fault vector type and codes for the segmented address generator.
// Assumes an 8-bit vector number field.
package seg_addr_pkg;
    typedef logic [7:0] vec_t;
    localparam vec_t VEC_NONE  = 8'd0;
    localparam vec_t VEC_STACK = 8'd12;
    localparam vec_t VEC_DATA  = 8'd13;
endpackage

// File: rtl/seg_base_adder.sv
// Module: seg_base_adder
// Shifts the segment value left by SHIFT bits, adds the zero-extended offset
// and keeps the carry in the top bit. When wrap_en is set, the top bit is
// cleared. Assumes OFS_W <= SEG_W + SHIFT.
module seg_base_adder #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int SUM_W = SEG_W + SHIFT + 1
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    input  logic             wrap_en,
    output logic [SUM_W-1:0] sum
);
    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] ofs_ext;
    logic [SUM_W-1:0] raw_sum;

    // Widen both operands to the full sum width.
    always_comb begin
        base_ext = {1'b0, seg, {SHIFT{1'b0}}};
        ofs_ext  = SUM_W'(ofs);
    end

    // Add with the carry kept, then drop the top bit if wrap is requested.
    always_comb begin
        raw_sum = base_ext + ofs_ext;
        sum     = raw_sum;
        if (wrap_en) begin
            sum[SUM_W-1] = 1'b0;
        end
    end
endmodule

// File: rtl/seg_fault_check.sv
// Module: seg_fault_check
// Checks the effective address against the segment limit (2**OFS_W - 1),
// both for the start offset and for the last byte of the operand. Picks the
// vector: stack accesses that are not fetches get the stack vector, all other
// faults get the data vector. Assumes EA_W >= OFS_W.
module seg_fault_check
    import seg_addr_pkg::*;
#(
    parameter int EA_W   = 32,
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 3
) (
    input  logic [EA_W-1:0]   ea,
    input  logic [SIZE_W-1:0] op_size,
    input  logic              stack_acc,
    input  logic              fetch_seq,
    output logic              fault,
    output vec_t              vec
);
    localparam logic [EA_W:0] LIMIT = (EA_W+1)'((64'd1 << OFS_W) - 64'd1);

    logic [EA_W:0] nbytes;
    logic [EA_W:0] end_ofs;
    logic          over_start;
    logic          over_end;

    // Decode the operand size; unknown codes count as one byte.
    always_comb begin
        case (op_size)
            SIZE_W'(2): nbytes = (EA_W+1)'(2);
            SIZE_W'(4): nbytes = (EA_W+1)'(4);
            default:    nbytes = (EA_W+1)'(1);
        endcase
    end

    // Find the last byte offset one bit wider, so it cannot overflow.
    always_comb begin
        end_ofs    = {1'b0, ea} + nbytes - (EA_W+1)'(1);
        over_start = ({1'b0, ea} > LIMIT);
        over_end   = (end_ofs > LIMIT);
    end

    // Combine the range checks and select the vector by segment kind.
    always_comb begin
        fault = over_start | over_end;
        if (!fault) begin
            vec = VEC_NONE;
        end else if (stack_acc && !fetch_seq) begin
            vec = VEC_STACK;
        end else begin
            vec = VEC_DATA;
        end
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Builds a linear address from the segment and the offset, and flags range and
// crossing faults. The output is zero while a fault is raised. With
// REG_OUT=1 the outputs pass through one register stage with synchronous
// active-low reset. With REG_OUT=0 they follow the inputs directly.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int EA_W    = 32,
    parameter int OFS_W   = 16,
    parameter int SHIFT   = 4,
    parameter int SIZE_W  = 3,
    parameter int LIN_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [EA_W-1:0]   eff_addr,
    input  logic [SIZE_W-1:0] op_size,
    input  logic              stack_acc,
    input  logic              fetch_seq,
    input  logic              wrap_en,
    output logic [LIN_W-1:0]  lin_addr,
    output logic              fault_vld,
    output logic [7:0]        fault_vec
);
    localparam int SUM_W = SEG_W + SHIFT + 1;

    logic [SUM_W-1:0] sum_c;
    logic             fault_c;
    vec_t             vec_c;
    logic [LIN_W-1:0] lin_c;

    seg_base_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_adder (
        .seg     (seg_val),
        .ofs     (eff_addr[OFS_W-1:0]),
        .wrap_en (wrap_en),
        .sum     (sum_c)
    );

    seg_fault_check #(.EA_W(EA_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)) u_check (
        .ea        (eff_addr),
        .op_size   (op_size),
        .stack_acc (stack_acc),
        .fetch_seq (fetch_seq),
        .fault     (fault_c),
        .vec       (vec_c)
    );

    // Drive a zero address on a fault, otherwise the zero-extended sum.
    always_comb begin
        lin_c = fault_c ? '0 : LIN_W'(sum_c);
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register stage, cleared by synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lin_addr  <= '0;
                    fault_vld <= 1'b0;
                    fault_vec <= VEC_NONE;
                end else begin
                    lin_addr  <= lin_c;
                    fault_vld <= fault_c;
                    fault_vec <= vec_c;
                end
            end

            // R3: an out-of-range offset seen one edge earlier shows as a fault now.
            a_r3_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && ($past(eff_addr) > EA_W'((64'd1 << OFS_W) - 64'd1)))
                |-> (fault_vld && (lin_addr == '0)));

            // R8: wrap enable seen one edge earlier leaves bit 20 clear.
            a_r8_wrap_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(wrap_en)) |-> !lin_addr[SUM_W-1]);

            // R7: a faulting fetch never carries the stack vector.
            a_r7_fetch_vector: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(fetch_seq) && fault_vld) |-> (fault_vec == VEC_DATA));
        end else begin : g_comb
            // Pass-through variant with no register stage.
            always_comb begin
                lin_addr  = lin_c;
                fault_vld = fault_c;
                fault_vec = vec_c;
            end
        end
    endgenerate

    // R2: address bits above the 21-bit sum stay zero.
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_addr >> SUM_W) == '0);

    // R6: a fault suppresses the address, and no fault means vector zero.
    a_r6_fault_clears_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> (lin_addr == '0));
    a_r6_no_fault_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_vld |-> (fault_vec == VEC_NONE));

    // R5: a raised fault only ever carries one of the two legal vectors.
    a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> ((fault_vec == VEC_STACK) || (fault_vec == VEC_DATA)));
endmodule

// File: tb/seg_addr_gen_test.sv
// Bench for seg_addr_gen with the default one-cycle output stage.
// A behavioural model predicts each vector's result, and the outputs are
// compared against it every clock.
module seg_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg_val = '0;
    logic [31:0] eff_addr = '0;
    logic [2:0]  op_size = 3'd1;
    logic        stack_acc = 1'b0;
    logic        fetch_seq = 1'b0;
    logic        wrap_en = 1'b0;
    logic [31:0] lin_addr;
    logic        fault_vld;
    logic [7:0]  fault_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] prev_lin = '0;
    logic        prev_flt = 1'b0;
    logic [7:0]  prev_vec = '0;

    always #2 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .seg_val(seg_val), .eff_addr(eff_addr),
        .op_size(op_size), .stack_acc(stack_acc), .fetch_seq(fetch_seq),
        .wrap_en(wrap_en), .lin_addr(lin_addr), .fault_vld(fault_vld),
        .fault_vec(fault_vec)
    );

    // Behavioural reference computed from the requirements.
    task automatic model(input int unsigned s, input longint unsigned ea, input int unsigned sz,
                         input bit stk, input bit fch, input bit wrp,
                         output logic [31:0] lin, output logic flt, output logic [7:0] vec);
        longint unsigned nb;
        longint unsigned full;
        nb = (sz == 2) ? 2 : (sz == 4) ? 4 : 1;
        flt = (ea > 65535) || (ea + nb - 1 > 65535);
        vec = !flt ? 8'd0 : (stk && !fch) ? 8'd12 : 8'd13;
        full = longint'(s) * 16 + (ea % 65536);
        if (wrp) full = full % 1048576;
        lin = flt ? 32'd0 : 32'(full);
    endtask

    task automatic compare(input string tag, input logic [31:0] el, input logic ef, input logic [7:0] ev);
        checks++;
        if (lin_addr !== el || fault_vld !== ef || fault_vec !== ev) begin
            errors++;
            $display("FAIL %s: got lin=%h flt=%b vec=%0d expected lin=%h flt=%b vec=%0d",
                     tag, lin_addr, fault_vld, fault_vec, el, ef, ev);
        end
    endtask

    // Drive at the falling edge, check the hold before the rising edge, then check the result after it.
    task automatic run(input logic [15:0] s, input logic [31:0] ea, input logic [2:0] sz,
                       input bit stk, input bit fch, input bit wrp, input string tag);
        logic [31:0] el;
        logic        ef;
        logic [7:0]  ev;
        seg_val = s; eff_addr = ea; op_size = sz;
        stack_acc = stk; fetch_seq = fch; wrap_en = wrp;
        model(s, ea, sz, stk, fch, wrp, el, ef, ev);
        #1;
        compare("R9 hold before edge", prev_lin, prev_flt, prev_vec);
        @(posedge clk); #1;
        compare(tag, el, ef, ev);
        prev_lin = el; prev_flt = ef; prev_vec = ev;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R9 reset clears outputs", 32'd0, 1'b0, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run(16'h1234, 32'h0000_0010, 3'd1, 0, 0, 0, "R1 basic sum");
        run(16'hFFFF, 32'h0000_FFFF, 3'd1, 0, 0, 0, "R2 highest address 0x10FFEF");
        run(16'hFFFF, 32'h0000_FFFF, 3'd1, 0, 0, 1, "R8 wrap gives 0x0FFEF");
        run(16'h0100, 32'h0001_0000, 3'd1, 0, 0, 0, "R3 offset above limit");
        run(16'h0100, 32'h0001_0000, 3'd1, 1, 0, 0, "R5 stack vector 12");
        run(16'h0200, 32'h0000_FFFF, 3'd2, 0, 0, 0, "R4 word crossing data");
        run(16'h0200, 32'h0000_FFFF, 3'd2, 1, 0, 0, "R5 word crossing stack");
        run(16'h0000, 32'h0000_FFFC, 3'd4, 0, 0, 0, "R4 dword at FFFC fits");
        run(16'h0000, 32'h0000_FFFD, 3'd4, 0, 0, 0, "R4 dword at FFFD faults");
        run(16'h0300, 32'h0000_FFFF, 3'd3, 0, 0, 0, "R4 odd size code is one byte");
        run(16'h0040, 32'h0000_FFFF, 3'd1, 1, 1, 0, "R7 fetch at last byte fits");
        run(16'h0040, 32'h0000_FFFF, 3'd2, 1, 1, 0, "R7 fetch overrun vector 13");
        run(16'hABCD, 32'hFFFF_FFFF, 3'd4, 0, 0, 0, "R3 all-ones offset");
        run(16'h8000, 32'h0000_1234, 3'd2, 0, 0, 0, "R6 no fault after fault");
        run(16'h0001, 32'h0002_0000, 3'd1, 0, 0, 1, "R6 fault with wrap still zero");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ea;
            ea = $urandom;
            case (i % 4)
                0: ea = 32'h0000_FFF8 + (ea % 16);
                1: ea = ea % 32'h0001_0000;
                2: ea = ea % 32'h0002_0000;
                default: ;
            endcase
            run(16'($urandom), ea, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                "R1 random vector");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule